// File: doc/BRIEF.md
# Serial PSRAM Command Sequencer

This block sits between a client that wants bytes read from or written to an external serial pseudo-static RAM and a single-line SPI transaction engine that shifts bits on the wire. The sequencer does not touch the wire itself. It emits frames as byte streams. Each frame starts with two header bytes: the number of bits to transmit and the number of bits to receive. The device command and its operands follow. The sequencer then consumes whatever bytes the engine returns.

Out of reset the block brings the device up on its own. It issues a reset-enable command, pauses, issues a reset command, and pauses again. It then reads the three identification bytes and decides whether the device is a good die and how large it is. Only after that does it accept client requests. A request carries a 24-bit byte address, a length, and a direction. Writes are cut into chunks of at most 24 bytes and reads into chunks of at most 4 bytes. The address moves forward by each chunk's length, wrapping at 24 bits. A single `done` pulse marks the end of the request.

All data streams are valid/ready. A valid, once raised, holds with stable data until ready is seen at a clock edge. Either side may hold ready low for any number of cycles. `tx_valid` never depends on `tx_ready`. Back-pressure on `rd_ready` stalls the engine's return stream, because `rx_ready` follows `rd_ready` during a read. Stalls on `wr_valid` or `tx_ready` delay the write data bytes one for one.

Top module: `psram_cmd_seq`

## Requirements
- R1: After reset the first frame is the bytes 8, 0, 0x66 with `tx_last` on the third byte. At least `ceil(CLK_HZ*50/1e6)` cycles pass with no frame. Then comes the frame 8, 0, 0x99, followed by at least `ceil(CLK_HZ*100/1e6)` quiet cycles before the next frame.
- R2: The identification frame is the six bytes 32, 24, 0x9F, 0, 0, 0. The sequencer then takes exactly three bytes from the return stream.
- R3: `dev_bytes` is 0 unless the second identification byte is 0x5D. If it is, bits [7:5] of the third byte give the size: 0 gives 2097152, 1 gives 4194304, 2 gives 8388608, and any other value gives 0.
- R4: `req_ready` stays low until `init_done` is high. `init_done` rises once the third identification byte has been taken.
- R5: A write chunk of n bytes is the frame 32+8n, 0, 0x02, address[23:16], address[15:8], address[7:0], followed by the n bytes taken from the write stream in order.
- R6: A read chunk of n bytes is the frame 40, 8n, 0x0B, address[23:16], address[15:8], address[7:0], 0. The n returned bytes reach the read stream in order.
- R7: A request is split into chunks of min(remaining, 24) bytes for writes and min(remaining, 4) bytes for reads. Each chunk address is the previous one plus the previous length, modulo 2^24.
- R8: A request of length 0 raises `done` in the cycle after acceptance and produces no frame.
- R9: `done` is high for one cycle, one cycle after the last write byte is taken by the engine or the last read byte is taken on the read stream. `req_ready` is high in that cycle, so a new request may be accepted together with `done`.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| init_done | output | 1 | device bring-up finished |
| dev_bytes | output | 32 | detected capacity in bytes, 0 if rejected |
| req_valid | input | 1 | request valid |
| req_ready | output | 1 | request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | start byte address |
| req_len | input | LEN_W | byte count |
| wr_valid | input | 1 | write data valid |
| wr_ready | output | 1 | write data taken |
| wr_data | input | 8 | write data byte |
| rd_valid | output | 1 | read data valid |
| rd_ready | input | 1 | read data taken |
| rd_data | output | 8 | read data byte |
| done | output | 1 | one-cycle completion pulse |
| tx_valid | output | 1 | frame byte valid to engine |
| tx_ready | input | 1 | engine takes frame byte |
| tx_data | output | 8 | frame byte |
| tx_last | output | 1 | last byte of frame |
| rx_valid | input | 1 | returned byte valid |
| rx_ready | output | 1 | returned byte taken |
| rx_data | input | 8 | returned byte |

## Verification
Two events can land in the same cycle: the completion pulse of one request and the acceptance of the next one. The bench provokes this by presenting each new request immediately after the previous `done` becomes visible. It records whether `done` was high in the same cycle as the accepting handshake and requires that this happened at least once. Each request must still see exactly its own pulse, timed one cycle after its last byte handshake. All of this runs under random back-pressure on the transmit, receive, write and read streams.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;
  localparam logic [7:0] OP_RST_EN = 8'h66;
  localparam logic [7:0] OP_RST    = 8'h99;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_FREAD  = 8'h0B;
  localparam logic [7:0] ID_GOOD   = 8'h5D;

  typedef enum logic [2:0] {
    ST_BOOT, ST_HDR, ST_WAIT_A, ST_WAIT_B, ST_ID_RX, ST_IDLE, ST_WDATA, ST_RDATA
  } seq_state_e;

  typedef enum logic [2:0] {FK_RSTEN, FK_RST, FK_ID, FK_WR, FK_RD} frame_kind_e;

  function automatic logic [2:0] hdr_last(frame_kind_e k);
    case (k)
      FK_RSTEN, FK_RST: return 3'd2;
      FK_RD:            return 3'd6;
      default:          return 3'd5;
    endcase
  endfunction

  function automatic logic [7:0] hdr_byte(frame_kind_e k, logic [2:0] i,
                                          logic [23:0] a, logic [7:0] n);
    logic [7:0] n8;
    logic [7:0] b;
    n8 = {n[4:0], 3'b000};
    b  = 8'h00;
    case (i)
      3'd0: case (k)
              FK_ID:   b = 8'd32;
              FK_WR:   b = 8'd32 + n8;
              FK_RD:   b = 8'd40;
              default: b = 8'd8;
            endcase
      3'd1: case (k)
              FK_ID:   b = 8'd24;
              FK_RD:   b = n8;
              default: b = 8'd0;
            endcase
      3'd2: case (k)
              FK_RSTEN: b = OP_RST_EN;
              FK_RST:   b = OP_RST;
              FK_ID:    b = OP_RDID;
              FK_WR:    b = OP_WRITE;
              default:  b = OP_FREAD;
            endcase
      3'd3: b = (k == FK_ID) ? 8'h00 : a[23:16];
      3'd4: b = (k == FK_ID) ? 8'h00 : a[15:8];
      3'd5: b = (k == FK_ID) ? 8'h00 : a[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R1: an armed wait counts down by exactly one per cycle
  a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/psram_id_decode.sv
module psram_id_decode
  import psram_seq_pkg::*;
(
  input  logic [7:0]  kgd_byte,
  input  logic [7:0]  dens_byte,
  output logic [31:0] cap_bytes
);
  logic [2:0] code;
  assign code = dens_byte[7:5];

  always_comb begin
    cap_bytes = 32'd0;
    if (kgd_byte == ID_GOOD && code <= 3'd2)
      cap_bytes = 32'd1 << (5'd21 + {2'b00, code});
  end
endmodule

// File: rtl/psram_chunker.sv
module psram_chunker #(
  parameter int LEN_W  = 16,
  parameter int WR_MAX = 24,
  parameter int RD_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic [23:0]      start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic             step,
  output logic [23:0]      cur_addr,
  output logic [7:0]       chunk_len,
  output logic             last_chunk
);
  localparam logic [LEN_W-1:0] WR_LIM = LEN_W'(WR_MAX);
  localparam logic [LEN_W-1:0] RD_LIM = LEN_W'(RD_MAX);

  logic [LEN_W-1:0] rem;
  logic             is_wr;
  logic [LEN_W-1:0] lim;

  assign lim        = is_wr ? WR_LIM : RD_LIM;
  assign chunk_len  = (rem < lim) ? 8'(rem) : 8'(lim);
  assign last_chunk = (rem <= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      is_wr    <= 1'b0;
      cur_addr <= '0;
    end else if (start) begin
      rem      <= start_len;
      is_wr    <= start_write;
      cur_addr <= start_addr;
    end else if (step) begin
      rem      <= rem - LEN_W'(chunk_len);
      cur_addr <= cur_addr + 24'(chunk_len);
    end
  end

  // R7: each chunk moves the address by that chunk's length
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start) |=> (cur_addr == $past(cur_addr) + 24'($past(chunk_len))));
endmodule

// File: rtl/psram_cmd_seq.sv
module psram_cmd_seq
  import psram_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int          LEN_W  = 16,
  parameter int          WR_MAX = 24,
  parameter int          RD_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             init_done,
  output logic [31:0]      dev_bytes,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data
);
  localparam longint unsigned WAIT_A_CYC = (64'(CLK_HZ) * 50 + 999_999) / 1_000_000;
  localparam longint unsigned WAIT_B_CYC = (64'(CLK_HZ) * 100 + 999_999) / 1_000_000;
  localparam int TW = $clog2(WAIT_B_CYC + 1);

  seq_state_e  state;
  frame_kind_e kind;
  logic [2:0]  hidx;
  logic [7:0]  bcnt;
  logic [7:0]  id_kgd, id_dens;
  logic        init_q, done_q;

  logic        tmr_load, tmr_busy;
  logic [TW-1:0] tmr_val;
  logic        ch_start, ch_step, ch_last;
  logic [23:0] ch_addr;
  logic [7:0]  ch_len;
  logic        wbyte_fire, rbyte_fire, chunk_end;

  psram_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .busy(tmr_busy));

  psram_chunker #(.LEN_W(LEN_W), .WR_MAX(WR_MAX), .RD_MAX(RD_MAX)) u_chunk (
    .clk(clk), .rst_n(rst_n), .start(ch_start), .start_write(req_write),
    .start_addr(req_addr), .start_len(req_len), .step(ch_step),
    .cur_addr(ch_addr), .chunk_len(ch_len), .last_chunk(ch_last));

  psram_id_decode u_id (.kgd_byte(id_kgd), .dens_byte(id_dens), .cap_bytes(dev_bytes));

  // stream views
  assign tx_valid  = (state == ST_HDR) || (state == ST_WDATA && wr_valid);
  assign tx_data   = (state == ST_WDATA) ? wr_data : hdr_byte(kind, hidx, ch_addr, ch_len);
  assign tx_last   = (state == ST_HDR && hidx == hdr_last(kind) && kind != FK_WR) ||
                     (state == ST_WDATA && bcnt == ch_len - 8'd1);
  assign wr_ready  = (state == ST_WDATA) && tx_ready;
  assign rx_ready  = (state == ST_ID_RX) || (state == ST_RDATA && rd_ready);
  assign rd_valid  = (state == ST_RDATA) && rx_valid;
  assign rd_data   = rx_data;
  assign req_ready = (state == ST_IDLE);
  assign init_done = init_q;
  assign done      = done_q;

  assign wbyte_fire = (state == ST_WDATA) && wr_valid && tx_ready;
  assign rbyte_fire = (state == ST_RDATA) && rx_valid && rd_ready;
  assign chunk_end  = (wbyte_fire || rbyte_fire) && (bcnt == ch_len - 8'd1);
  assign ch_step    = chunk_end;
  assign ch_start   = (state == ST_IDLE) && req_valid && (req_len != '0);

  assign tmr_load = (state == ST_HDR) && tx_ready && (hidx == hdr_last(kind)) &&
                    (kind == FK_RSTEN || kind == FK_RST);
  assign tmr_val  = (kind == FK_RSTEN) ? TW'(WAIT_A_CYC) : TW'(WAIT_B_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_BOOT;
      kind    <= FK_RSTEN;
      hidx    <= '0;
      bcnt    <= '0;
      id_kgd  <= '0;
      id_dens <= '0;
      init_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_BOOT: state <= ST_HDR;
        ST_HDR: if (tx_ready) begin
          if (hidx == hdr_last(kind)) begin
            hidx <= '0;
            bcnt <= '0;
            case (kind)
              FK_RSTEN: state <= ST_WAIT_A;
              FK_RST:   state <= ST_WAIT_B;
              FK_ID:    state <= ST_ID_RX;
              FK_WR:    state <= ST_WDATA;
              default:  state <= ST_RDATA;
            endcase
          end else begin
            hidx <= hidx + 3'd1;
          end
        end
        ST_WAIT_A: if (!tmr_busy) begin
          kind  <= FK_RST;
          state <= ST_HDR;
        end
        ST_WAIT_B: if (!tmr_busy) begin
          kind  <= FK_ID;
          state <= ST_HDR;
        end
        ST_ID_RX: if (rx_valid) begin
          if (bcnt == 8'd1) id_kgd <= rx_data;
          if (bcnt == 8'd2) begin
            id_dens <= rx_data;
            init_q  <= 1'b1;
            state   <= ST_IDLE;
          end
          bcnt <= bcnt + 8'd1;
        end
        ST_IDLE: if (req_valid) begin
          if (req_len == '0) done_q <= 1'b1;
          else begin
            kind  <= req_write ? FK_WR : FK_RD;
            hidx  <= '0;
            state <= ST_HDR;
          end
        end
        ST_WDATA, ST_RDATA: if (wbyte_fire || rbyte_fire) begin
          if (chunk_end) begin
            bcnt <= '0;
            if (ch_last) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_HDR;
            end
          end else begin
            bcnt <= bcnt + 8'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: no request is taken before bring-up ends
  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);
  // R8: empty request finishes at once without a frame
  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (done && req_ready && !tx_valid));
  // R1: the engine sees nothing while a wait interval runs
  a_r1_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !tx_valid);
  // R10: a stalled frame byte holds
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R9: completion is flagged only when the port is open again
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  // R6: read data only flows from returned engine bytes
  a_r6_rd_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rx_valid);
endmodule

// File: tb/psram_cmd_seq_bench.sv
`timescale 1ns/100ps
module psram_cmd_seq_bench;
  localparam int unsigned CLK_HZ = 4_000_000;
  localparam int LEN_W = 16;
  localparam longint WA = (longint'(CLK_HZ) * 50 + 999_999) / 1_000_000;
  localparam longint WB = (longint'(CLK_HZ) * 100 + 999_999) / 1_000_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_done, req_ready, wr_ready, rd_valid, done, tx_valid, tx_last, rx_ready;
  logic [31:0] dev_bytes;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] wr_data = '0, rd_data, tx_data, rx_data = '0;

  always #2 clk = ~clk;

  psram_cmd_seq #(.CLK_HZ(CLK_HZ), .LEN_W(LEN_W)) u_psram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .dev_bytes(dev_bytes),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // engine / device model state
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] mem [0:255];
  logic [7:0] ref_mem [0:255];
  logic [7:0] fb [0:63];
  int fn = 0, nf = 0;
  logic [7:0] f_cmd [0:255], f_tx [0:255], f_rx [0:255], f_dum [0:255];
  logic [23:0] f_addr [0:255];
  int f_bytes [0:255], f_first [0:255], f_lastc [0:255];
  int cur_first = 0;
  logic [7:0] rx_src [0:63];
  int rx_left = 0, rx_pos = 0;
  logic [7:0] id_b1 = 8'h5D, id_b2 = 8'h40;
  logic [7:0] wr_src [0:1023];
  int wi = 0, wn = 0;
  logic [7:0] rd_buf [0:1023];
  int ri = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0, last_tx_cyc = 0, last_rd_cyc = 0;
  int coincide = 0, gate_bad = 0, hold_bad = 0;
  bit wr_took = 0, rx_took = 0, prev_stall = 0;
  logic [7:0] prev_data = '0;

  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      tx_ready = 0; rx_valid = 0; wr_valid = 0; rd_ready = 0;
      fn = 0; rx_left = 0; rx_pos = 0; wr_took = 0; rx_took = 0; prev_stall = 0;
    end else begin
      if (wr_took) wr_valid = 0;
      if (rx_took) rx_valid = 0;
      wr_took = 0; rx_took = 0;
      tx_ready = lfsr[0] | lfsr[3];
      rd_ready = lfsr[1] | lfsr[4];
      if (!rx_valid && rx_left > 0 && (lfsr[2] | lfsr[5])) begin
        rx_valid = 1; rx_data = rx_src[rx_pos];
      end
      if (!wr_valid && wi < wn && (lfsr[6] | lfsr[7])) begin
        wr_valid = 1; wr_data = wr_src[wi];
      end
    end
    #1;
    if (rst_n) begin
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (req_ready && !init_done) gate_bad++;
      if (prev_stall && !(tx_valid && tx_data == prev_data)) hold_bad++;
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        if (fn == 0) cur_first = cyc;
        fb[fn] = tx_data; fn++;
        last_tx_cyc = cyc;
        if (tx_last) begin
          f_cmd[nf] = fb[2]; f_tx[nf] = fb[0]; f_rx[nf] = fb[1];
          f_addr[nf] = (fn >= 6) ? {fb[3], fb[4], fb[5]} : 24'h0;
          f_dum[nf] = (fn >= 7) ? fb[6] : 8'h0;
          f_bytes[nf] = fn; f_first[nf] = cur_first; f_lastc[nf] = cyc;
          if (fb[2] == 8'h02)
            for (int j = 6; j < fn; j++) mem[8'(f_addr[nf] + 24'(j - 6))] = fb[j];
          if (fb[1] != 0) begin
            rx_left = fb[1] / 8; rx_pos = 0;
            for (int j = 0; j < rx_left; j++)
              rx_src[j] = (fb[2] == 8'h9F) ? ((j == 0) ? 8'h0D : (j == 1) ? id_b1 : id_b2)
                                           : mem[8'(f_addr[nf] + 24'(j))];
          end
          nf++; fn = 0;
        end
      end
      if (wr_valid && wr_ready) begin wi++; wr_took = 1; end
      if (rx_valid && rx_ready) begin rx_pos++; rx_left--; rx_took = 1; end
      if (rd_valid && rd_ready) begin rd_buf[ri] = rd_data; ri++; last_rd_cyc = cyc; end
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic bring_up(input logic [7:0] b1, input logic [7:0] b2);
    int base, t;
    longint exp_sz;
    @(negedge clk);
    rst_n = 0; id_b1 = b1; id_b2 = b2;
    repeat (3) @(negedge clk);
    #1.5;
    chk(!tx_valid && !req_ready && !init_done && !done && dev_bytes == 0,
        "R4", "reset state", {tx_valid, req_ready, init_done, done}, 0);
    base = nf;
    @(negedge clk); rst_n = 1;
    t = 0;
    while (!init_done && t < 3000) begin @(negedge clk); #1.5; t++; end
    chk(init_done, "R4", "init_done rises", init_done, 1);
    chk(nf - base == 3, "R2", "bring-up frame count", nf - base, 3);
    chk(f_tx[base] == 8 && f_rx[base] == 0 && f_cmd[base] == 8'h66 && f_bytes[base] == 3,
        "R1", "reset-enable frame", f_cmd[base], 8'h66);
    chk(f_tx[base+1] == 8 && f_rx[base+1] == 0 && f_cmd[base+1] == 8'h99 && f_bytes[base+1] == 3,
        "R1", "reset frame", f_cmd[base+1], 8'h99);
    chk(f_first[base+1] - f_lastc[base] >= WA, "R1", "first wait cycles",
        f_first[base+1] - f_lastc[base], WA);
    chk(f_first[base+2] - f_lastc[base+1] >= WB, "R1", "second wait cycles",
        f_first[base+2] - f_lastc[base+1], WB);
    chk(f_tx[base+2] == 32 && f_rx[base+2] == 24 && f_cmd[base+2] == 8'h9F &&
        f_addr[base+2] == 0 && f_bytes[base+2] == 6, "R2", "id frame", f_cmd[base+2], 8'h9F);
    chk(rx_left == 0, "R2", "id bytes consumed", rx_left, 0);
    exp_sz = 0;
    if (b1 == 8'h5D && b2[7:5] <= 2) exp_sz = longint'(2097152) << b2[7:5];
    chk(dev_bytes == exp_sz, "R3", "size", dev_bytes, exp_sz);
    chk(req_ready, "R4", "ready after init", req_ready, 1);
  endtask

  task automatic run_req(input bit wr, input logic [23:0] addr, input int len, input int seed);
    int fbase, rbase, dbase, t, pos, k, mx, n, bad_i;
    bit ok;
    mx = wr ? 24 : 4;
    if (wr) begin
      for (int j = 0; j < len; j++) begin
        wr_src[wn + j] = 8'(seed + j * 7);
        ref_mem[8'(addr + 24'(j))] = 8'(seed + j * 7);
      end
      wn = wn + len;
    end
    fbase = nf; rbase = ri;
    req_valid = 1; req_write = wr; req_addr = addr; req_len = LEN_W'(len);
    t = 0;
    while (!req_ready && t < 5000) begin @(negedge clk); #1.5; t++; end
    if (done) coincide++;
    dbase = done_cnt;
    t = cyc;
    @(negedge clk); req_valid = 0;
    #1.5;
    while (done_cnt == dbase && cyc - t < 5000) begin @(negedge clk); #1.5; end
    chk(done_cnt == dbase + 1, "R9", "one done", done_cnt - dbase, 1);
    if (len == 0) begin
      chk(done_cyc == t + 1 && nf == fbase, "R8", "empty request", done_cyc - t, 1);
      return;
    end
    chk(done_cyc == (wr ? last_tx_cyc : last_rd_cyc) + 1, "R9", "done timing",
        done_cyc, (wr ? last_tx_cyc : last_rd_cyc) + 1);
    chk(nf - fbase == (len + mx - 1) / mx, "R7", "chunk count", nf - fbase, (len + mx - 1) / mx);
    pos = 0; k = fbase;
    while (pos < len && k < nf) begin
      n = (len - pos < mx) ? len - pos : mx;
      if (wr)
        chk(f_cmd[k] == 8'h02 && f_tx[k] == 8'(32 + 8 * n) && f_rx[k] == 0 &&
            f_bytes[k] == 6 + n && f_addr[k] == addr + 24'(pos),
            "R5", "write frame addr", f_addr[k], addr + 24'(pos));
      else
        chk(f_cmd[k] == 8'h0B && f_tx[k] == 40 && f_rx[k] == 8'(8 * n) &&
            f_bytes[k] == 7 && f_dum[k] == 0 && f_addr[k] == addr + 24'(pos),
            "R6", "read frame addr", f_addr[k], addr + 24'(pos));
      pos += n; k++;
    end
    if (!wr) begin
      ok = (ri - rbase == len); bad_i = -1;
      for (int j = 0; j < len && j < ri - rbase; j++)
        if (rd_buf[rbase + j] != ref_mem[8'(addr + 24'(j))] && bad_i < 0) begin
          ok = 0; bad_i = j;
        end
      chk(ok, "R6", "read data", (bad_i < 0) ? ri - rbase : rd_buf[rbase + bad_i],
          (bad_i < 0) ? len : ref_mem[8'(addr + 24'(bad_i))]);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i ^ 8'h5A); ref_mem[i] = 8'(i ^ 8'h5A); end
    for (int v = 0; v < 8; v++) bring_up(8'h5D, {3'(v), 5'h13});
    bring_up(8'h5C, 8'h40);
    bring_up(8'h5D, 8'h40);
    @(negedge clk); #1.5;
    run_req(1, 24'h000000, 0, 0);
    run_req(0, 24'h000010, 0, 0);
    for (int l = 1; l <= 49; l += 6) run_req(1, 24'(8 * l), l, l * 3);
    run_req(1, 24'h000040, 24, 200);
    run_req(1, 24'h000060, 25, 100);
    for (int l = 1; l <= 13; l++) run_req(0, 24'(8 * l + 1), l, 0);
    run_req(0, 24'h000040, 24, 0);
    run_req(1, 24'hFFFFF8, 30, 77);
    run_req(0, 24'hFFFFFC, 9, 0);
    run_req(0, 24'hFFFFF8, 30, 0);
    chk(coincide > 0, "R9", "done with next accept", coincide, 1);
    chk(gate_bad == 0, "R4", "ready before init", gate_bad, 0);
    chk(hold_bad == 0, "R10", "tx hold under stall", hold_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule